// File: doc/BRIEF.md
# Four-Bit ECC Correction Sequencer

This block runs the correction phase of a 4-bit Reed-Solomon style ECC engine once a 512-byte sector has been read from flash. A single `start` pulse comes with the ten ECC bytes that were stored beside the sector. The sequencer first decides whether the sector is erased. If it is not, it unpacks the stored bytes into eight 10-bit expected codes and feeds them to the engine. It then reads back the four syndrome words. If any syndrome is non-zero, it starts the engine's error-address calculation and polls the engine's status word until results are ready.

When results are ready, it fetches up to four packed address/value pairs. Each engine address is mapped to a byte offset inside the sector. Every in-range error becomes one (offset, XOR mask) command on a valid/ready output stream. A one-cycle done pulse then reports the final status and the number of commands issued. The engine's arithmetic and the sector buffer live outside the block.

Engine registers are reached through a single read port with a 3-bit selector. Codes are written through a separate load port, and the engine status word is visible at all times. The block deals with one engine quirk: just after the calculation is kicked, the state field can show 3 ("complete") before any work has been done.

Top module: `ecc4_fix_seq`

## Requirements
- R1: When every bit of `stored_code` is 1 (ten 0xFF bytes) at `start`, the block pulses `done` with `done_status`=0 (erased) and `done_count`=0. It makes no load, read or calc-start access. Any other value takes the full path.
- R2: Expected code k (k=0..7) is `stored_code[10k+9:10k]`. The eight codes are written on `eng_load_data` in consecutive `eng_load_en` cycles, code 7 first and code 0 last.
- R3: After the loads, the block reads selectors 0,1,2,3 (syndrome words). If all four read zero, it pulses `done` with status 1 (clean) and count 0, and never asserts `eng_calc_start`.
- R4: If any syndrome is non-zero, the block makes exactly one read of selector 4 (first error-address register) in the cycle immediately before its single `eng_calc_start` pulse.
- R5: After the calc start, the block ignores state values below 4 in `eng_status[11:8]`, including 3. It leaves this wait when the state reaches 4 or more, or after PREWAIT_CYCLES cycles, and then polls normally. Its first read after the kick comes at a cycle computable from those rules.
- R6: While polling, state 4..15 keeps polling. State 0 ends with one read of selector 6 and done status 1. State 1 ends with one read of selector 6 and done status 3 (uncorrectable), count 0.
- R7: States 2 and 3 mean results are ready, with 1 + `eng_status[17:16]` errors. Errors 0 and 1 read selectors 4 (address) then 6 (value). Errors 2 and 3 read selectors 5 then 7. Even errors use bits 9:0 (address) and 7:0 (value). Odd errors use bits 25:16 and 23:16.
- R8: The offset is 519 minus the 10-bit address. Only results from 0 to 511 produce a command with that offset and the value as mask. `done_count` equals the number of commands, with status 2 (corrected).
- R9: A command shown with `fix_valid` and low `fix_ready` keeps `fix_valid`, `fix_offset` and `fix_mask` unchanged in the next cycle. Commands leave in error order.
- R10: `done` is a single-cycle pulse. `start` is ignored while a sector is in progress. After reset, all strobes and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin correction of one sector |
| stored_code | input | 80 | Ten stored ECC bytes, byte i at bits 8i+7:8i |
| eng_load_en | output | 1 | Write strobe of the engine code-load port |
| eng_load_data | output | 10 | Expected code value written to the engine |
| eng_rd_en | output | 1 | Engine register read strobe |
| eng_rd_sel | output | 3 | Read selector: 0-3 syndrome, 4/5 error address, 6/7 error value |
| eng_rd_data | input | 32 | Read data, valid in the cycle of the strobe |
| eng_calc_start | output | 1 | Kick the error-address calculation |
| eng_status | input | 32 | Engine status word: state in 11:8, error count minus one in 17:16 |
| fix_valid | output | 1 | Correction command valid |
| fix_ready | input | 1 | Correction command accepted |
| fix_offset | output | 9 | Byte offset in the sector |
| fix_mask | output | 8 | XOR mask for that byte |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 erased, 1 clean, 2 corrected, 3 uncorrectable |
| done_count | output | 3 | Number of correction commands issued |

## Verification
The bench builds the block with PREWAIT_CYCLES set to 16 and the default 512-byte sector with 10-bit codes. The short wait lets every path be swept in a few dozen cycles: the wait ending on a busy state, ending on its timeout, and a false "complete" state that outlasts the timeout. For each, the bench computes the exact cycle of the first result read. Sweeping every final state and every packed error count against a table of addresses covers the offset boundaries: 7 and 8, 519 and 520, and 0 and 1023. Both halves of both register pairs are exercised, and the output stream is throttled by a pseudo-random ready.

// File: rtl/ecc4_fix_pkg.sv
package ecc4_fix_pkg;

   localparam int REG_W      = 32;
   localparam int SYN_WORDS  = 4;
   localparam int ERR_MAX    = 4;
   localparam int ST_LSB     = 8;
   localparam int ST_W       = 4;
   localparam int NERR_LSB   = 16;
   localparam int HALF_LSB   = 16;
   localparam int MASK_W     = 8;

   localparam logic [2:0] RSEL_ADDR_LO = 3'd4;
   localparam logic [2:0] RSEL_ADDR_HI = 3'd5;
   localparam logic [2:0] RSEL_VAL_LO  = 3'd6;
   localparam logic [2:0] RSEL_VAL_HI  = 3'd7;

   typedef enum logic [1:0] {
      FIX_ERASED  = 2'd0,
      FIX_CLEAN   = 2'd1,
      FIX_REPAIRED= 2'd2,
      FIX_FAILED  = 2'd3
   } fix_result_e;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_SYN,
      SQ_JUDGE,
      SQ_FLUSH,
      SQ_KICK,
      SQ_HOLD,
      SQ_POLL,
      SQ_TAIL,
      SQ_GET_ADDR,
      SQ_GET_VAL,
      SQ_EMIT,
      SQ_DONE
   } seq_state_e;

endpackage

// File: rtl/ecc4_code_unpack.sv
module ecc4_code_unpack #(
   parameter int CODE_W    = 10,
   parameter int NUM_CODES = 8
) (
   input  logic [CODE_W*NUM_CODES-1:0]           packed_code,
   output logic [NUM_CODES-1:0][CODE_W-1:0]      codes,
   output logic                                  all_ones
);

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_slice
      assign codes[k] = packed_code[k*CODE_W +: CODE_W];
   end

   assign all_ones = &packed_code;

endmodule

// File: rtl/ecc4_prewait_timer.sv
module ecc4_prewait_timer #(
   parameter int CYCLES = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   if (CYCLES == 0) begin : g_none
      logic unused_tmr;
      assign unused_tmr = &{1'b0, clk, rst_n, clear, run};
      assign expired = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (clear)
            cnt <= '0;
         else if (run && !expired)
            cnt <= cnt + 1'b1;
      end

      assign expired = (cnt >= LAST);
   end

endmodule

// File: rtl/ecc4_err_decode.sv
module ecc4_err_decode
   import ecc4_fix_pkg::*;
#(
   parameter int SECTOR_BYTES = 512,
   parameter int ADDR_W       = 10,
   localparam int OFS_W       = $clog2(SECTOR_BYTES)
) (
   input  logic [REG_W-1:0]  addr_word,
   input  logic [REG_W-1:0]  val_word,
   input  logic              upper,
   output logic [OFS_W-1:0]  offset,
   output logic [MASK_W-1:0] mask,
   output logic              in_range
);

   localparam int DW = ADDR_W + 1;
   localparam logic [DW-1:0] BIAS  = DW'(SECTOR_BYTES + 7);
   localparam logic [DW-1:0] LIMIT = DW'(SECTOR_BYTES);

   logic [ADDR_W-1:0] raw_addr;
   logic [DW-1:0]     diff;
   logic              unused_bits;

   assign raw_addr = upper ? addr_word[HALF_LSB +: ADDR_W] : addr_word[0 +: ADDR_W];
   assign mask     = upper ? val_word[HALF_LSB +: MASK_W]  : val_word[0 +: MASK_W];
   assign diff     = BIAS - {1'b0, raw_addr};
   assign in_range = !diff[DW-1] && (diff < LIMIT);
   assign offset   = diff[OFS_W-1:0];

   assign unused_bits = ^{addr_word[REG_W-1:HALF_LSB+ADDR_W], addr_word[HALF_LSB-1:ADDR_W],
                          val_word[REG_W-1:HALF_LSB+MASK_W], val_word[HALF_LSB-1:MASK_W]};

endmodule

// File: rtl/ecc4_fix_seq.sv
module ecc4_fix_seq
   import ecc4_fix_pkg::*;
#(
   parameter int SECTOR_BYTES   = 512,
   parameter int CODE_W         = 10,
   parameter int NUM_CODES      = 8,
   parameter int PREWAIT_CYCLES = 10000
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic [CODE_W*NUM_CODES-1:0]     stored_code,
   output logic                            eng_load_en,
   output logic [CODE_W-1:0]               eng_load_data,
   output logic                            eng_rd_en,
   output logic [2:0]                      eng_rd_sel,
   input  logic [31:0]                     eng_rd_data,
   output logic                            eng_calc_start,
   input  logic [31:0]                     eng_status,
   output logic                            fix_valid,
   input  logic                            fix_ready,
   output logic [$clog2(SECTOR_BYTES)-1:0] fix_offset,
   output logic [7:0]                      fix_mask,
   output logic                            done,
   output logic [1:0]                      done_status,
   output logic [2:0]                      done_count
);

   localparam int STORE_W = CODE_W * NUM_CODES;
   localparam int IDX_W   = $clog2(NUM_CODES);
   localparam int SYN_IW  = $clog2(SYN_WORDS);
   localparam int CNT_W   = $clog2(ERR_MAX + 1);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_CODES - 1);

   if (STORE_W % 8 != 0) begin : g_bad_bytes
      $error("stored code must be a whole number of bytes");
   end
   if (SECTOR_BYTES + 7 >= (1 << CODE_W)) begin : g_bad_bias
      $error("sector too large for the engine address width");
   end
   if (CNT_W != 3) begin : g_bad_cnt
      $error("done_count width does not match the error limit");
   end

   seq_state_e                    state;
   logic [NUM_CODES-1:0][CODE_W-1:0] codes;
   logic                          erased;
   logic [IDX_W-1:0]              load_idx;
   logic [SYN_IW-1:0]             syn_idx;
   logic                          syn_hit;
   logic [CNT_W-1:0]              err_total;
   logic [1:0]                    err_idx;
   logic [REG_W-1:0]              addr_q;
   logic [REG_W-1:0]              val_q;
   logic [CNT_W-1:0]              fix_cnt;
   fix_result_e                   result_q;
   logic                          timer_expired;
   logic                          dec_in_range;
   logic [ST_W-1:0]               eng_state;
   logic [1:0]                    eng_nerr;
   logic                          unused_status;

   assign eng_state = eng_status[ST_LSB +: ST_W];
   assign eng_nerr  = eng_status[NERR_LSB +: 2];
   assign unused_status = ^{eng_status[31:NERR_LSB+2], eng_status[NERR_LSB-1:ST_LSB+ST_W],
                            eng_status[ST_LSB-1:0]};

   ecc4_code_unpack #(
      .CODE_W    (CODE_W),
      .NUM_CODES (NUM_CODES)
   ) u_unpack (
      .packed_code (stored_code),
      .codes       (codes),
      .all_ones    (erased)
   );

   ecc4_prewait_timer #(
      .CYCLES (PREWAIT_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (state == SQ_KICK),
      .run     (state == SQ_HOLD),
      .expired (timer_expired)
   );

   ecc4_err_decode #(
      .SECTOR_BYTES (SECTOR_BYTES),
      .ADDR_W       (CODE_W)
   ) u_decode (
      .addr_word (addr_q),
      .val_word  (val_q),
      .upper     (err_idx[0]),
      .offset    (fix_offset),
      .mask      (fix_mask),
      .in_range  (dec_in_range)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         load_idx  <= '0;
         syn_idx   <= '0;
         syn_hit   <= 1'b0;
         err_total <= '0;
         err_idx   <= '0;
         addr_q    <= '0;
         val_q     <= '0;
         fix_cnt   <= '0;
         result_q  <= FIX_CLEAN;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  fix_cnt <= '0;
                  if (erased) begin
                     result_q <= FIX_ERASED;
                     state    <= SQ_DONE;
                  end else begin
                     load_idx <= TOP_IDX;
                     state    <= SQ_LOAD;
                  end
               end
            end
            SQ_LOAD: begin
               if (load_idx == '0) begin
                  syn_idx <= '0;
                  syn_hit <= 1'b0;
                  state   <= SQ_SYN;
               end else begin
                  load_idx <= load_idx - 1'b1;
               end
            end
            SQ_SYN: begin
               syn_hit <= syn_hit | (|eng_rd_data);
               if (syn_idx == SYN_IW'(SYN_WORDS - 1))
                  state <= SQ_JUDGE;
               else
                  syn_idx <= syn_idx + 1'b1;
            end
            SQ_JUDGE: begin
               if (syn_hit) begin
                  state <= SQ_FLUSH;
               end else begin
                  result_q <= FIX_CLEAN;
                  state    <= SQ_DONE;
               end
            end
            SQ_FLUSH: state <= SQ_KICK;
            SQ_KICK:  state <= SQ_HOLD;
            SQ_HOLD: begin
               if (eng_state >= 4'd4 || timer_expired)
                  state <= SQ_POLL;
            end
            SQ_POLL: begin
               case (eng_state)
                  4'd0: begin
                     result_q <= FIX_CLEAN;
                     state    <= SQ_TAIL;
                  end
                  4'd1: begin
                     result_q <= FIX_FAILED;
                     state    <= SQ_TAIL;
                  end
                  4'd2, 4'd3: begin
                     err_total <= CNT_W'(eng_nerr) + 1'b1;
                     err_idx   <= '0;
                     state     <= SQ_GET_ADDR;
                  end
                  default: state <= SQ_POLL;
               endcase
            end
            SQ_TAIL: state <= SQ_DONE;
            SQ_GET_ADDR: begin
               addr_q <= eng_rd_data;
               state  <= SQ_GET_VAL;
            end
            SQ_GET_VAL: begin
               val_q <= eng_rd_data;
               state <= SQ_EMIT;
            end
            SQ_EMIT: begin
               if (!dec_in_range || fix_ready) begin
                  if (dec_in_range)
                     fix_cnt <= fix_cnt + 1'b1;
                  if ({1'b0, err_idx} == err_total - 1'b1) begin
                     result_q <= FIX_REPAIRED;
                     state    <= SQ_DONE;
                  end else begin
                     err_idx <= err_idx + 1'b1;
                     state   <= SQ_GET_ADDR;
                  end
               end
            end
            SQ_DONE: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      eng_rd_en  = 1'b0;
      eng_rd_sel = 3'd0;
      case (state)
         SQ_SYN: begin
            eng_rd_en  = 1'b1;
            eng_rd_sel = {1'b0, syn_idx};
         end
         SQ_FLUSH: begin
            eng_rd_en  = 1'b1;
            eng_rd_sel = RSEL_ADDR_LO;
         end
         SQ_TAIL: begin
            eng_rd_en  = 1'b1;
            eng_rd_sel = RSEL_VAL_LO;
         end
         SQ_GET_ADDR: begin
            eng_rd_en  = 1'b1;
            eng_rd_sel = err_idx[1] ? RSEL_ADDR_HI : RSEL_ADDR_LO;
         end
         SQ_GET_VAL: begin
            eng_rd_en  = 1'b1;
            eng_rd_sel = err_idx[1] ? RSEL_VAL_HI : RSEL_VAL_LO;
         end
         default: ;
      endcase
   end

   assign eng_load_en    = (state == SQ_LOAD);
   assign eng_load_data  = codes[load_idx];
   assign eng_calc_start = (state == SQ_KICK);
   assign fix_valid      = (state == SQ_EMIT) && dec_in_range;
   assign done           = (state == SQ_DONE);
   assign done_status    = result_q;
   assign done_count     = fix_cnt;

endmodule

// File: rtl/ecc4_fix_sva.sv
module ecc4_fix_sva #(
   parameter int SECTOR_BYTES = 512
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            eng_load_en,
   input logic                            eng_rd_en,
   input logic [2:0]                      eng_rd_sel,
   input logic                            eng_calc_start,
   input logic                            fix_valid,
   input logic                            fix_ready,
   input logic [$clog2(SECTOR_BYTES)-1:0] fix_offset,
   input logic [7:0]                      fix_mask,
   input logic                            done,
   input logic [1:0]                      done_status,
   input logic [2:0]                      done_count
);

   // R1: an erased sector reports no corrections
   a_r1_erased_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status == 2'd0) |-> done_count == 3'd0);

   // R2: the syndrome read follows the last code load at once
   a_r2_load_then_syn: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(eng_load_en) |-> (eng_rd_en && eng_rd_sel == 3'd0));

   // R4: the stale-result read comes right before the kick
   a_r4_flush_before_kick: assert property (@(posedge clk) disable iff (!rst_n)
      eng_calc_start |-> ($past(eng_rd_en) && $past(eng_rd_sel) == 3'd4));

   // R6: an uncorrectable sector reports no corrections
   a_r6_failed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_status == 2'd3) |-> done_count == 3'd0);

   // R8: never more corrections than the engine can report
   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> done_count <= 3'd4);

   // R9: a stalled command stays put
   a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_valid && !fix_ready) |=> (fix_valid && $stable(fix_offset) && $stable(fix_mask)));

   // R10: completion is a single-cycle pulse
   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind ecc4_fix_seq ecc4_fix_sva #(.SECTOR_BYTES(SECTOR_BYTES)) i_sva (.*);

// File: tb/test_ecc4_fix_seq.sv
module test_ecc4_fix_seq;

   localparam int P  = 16;
   localparam int SB = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start;
   logic [79:0] stored_code;
   logic        eng_load_en;
   logic [9:0]  eng_load_data;
   logic        eng_rd_en;
   logic [2:0]  eng_rd_sel;
   logic [31:0] eng_rd_data;
   logic        eng_calc_start;
   logic [31:0] eng_status;
   logic        fix_valid;
   logic        fix_ready;
   logic [8:0]  fix_offset;
   logic [7:0]  fix_mask;
   logic        done;
   logic [1:0]  done_status;
   logic [2:0]  done_count;

   always #5 clk = ~clk;

   ecc4_fix_seq #(.PREWAIT_CYCLES(P)) i_ecc4_fix_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stored_code(stored_code),
      .eng_load_en(eng_load_en), .eng_load_data(eng_load_data),
      .eng_rd_en(eng_rd_en), .eng_rd_sel(eng_rd_sel), .eng_rd_data(eng_rd_data),
      .eng_calc_start(eng_calc_start), .eng_status(eng_status),
      .fix_valid(fix_valid), .fix_ready(fix_ready), .fix_offset(fix_offset),
      .fix_mask(fix_mask), .done(done), .done_status(done_status), .done_count(done_count)
   );

   // engine model
   logic [31:0] syn_r [4];
   logic [31:0] err_a [2];
   logic [31:0] err_v [2];
   int          fake_len, busy_len, age;
   logic [3:0]  final_st;
   logic [1:0]  final_cnt;

   always_comb begin
      case (eng_rd_sel)
         3'd4:    eng_rd_data = err_a[0];
         3'd5:    eng_rd_data = err_a[1];
         3'd6:    eng_rd_data = err_v[0];
         3'd7:    eng_rd_data = err_v[1];
         default: eng_rd_data = syn_r[eng_rd_sel[1:0]];
      endcase
   end

   always_comb begin
      logic [31:0] w;
      w = 32'hA5A4_F0F5;
      if (age < fake_len)                 w[11:8] = 4'd3;
      else if (age < fake_len + busy_len) w[11:8] = 4'd12;
      else                                w[11:8] = final_st;
      w[17:16] = final_cnt;
      eng_status = w;
   end

   initial age = 100000;
   always @(posedge clk) begin
      if (eng_calc_start) age <= 0;
      else if (age < 100000) age <= age + 1;
   end

   // ready source
   logic [7:0] lfsr = 8'h5B;
   bit         ready_mode;
   always @(negedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      fix_ready <= ready_mode ? lfsr[0] : 1'b1;
   end

   // monitors
   bit log_clr;
   int cyc;
   int load_log [16];
   int rd_sel_log [32];
   int rd_cyc_log [32];
   int cmd_off [8];
   int cmd_mask [8];
   int n_load, n_rd, n_calc, calc_cyc, n_cmd, n_done, last_status, last_count;

   initial cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (log_clr) begin
         n_load <= 0; n_rd <= 0; n_calc <= 0; n_cmd <= 0; n_done <= 0;
      end else if (rst_n) begin
         if (eng_load_en) begin
            if (n_load < 16) load_log[n_load] <= int'(eng_load_data);
            n_load <= n_load + 1;
         end
         if (eng_rd_en) begin
            if (n_rd < 32) begin
               rd_sel_log[n_rd] <= int'(eng_rd_sel);
               rd_cyc_log[n_rd] <= cyc;
            end
            n_rd <= n_rd + 1;
         end
         if (eng_calc_start) begin
            calc_cyc <= cyc;
            n_calc   <= n_calc + 1;
         end
         if (fix_valid && fix_ready) begin
            if (n_cmd < 8) begin
               cmd_off[n_cmd]  <= int'(fix_offset);
               cmd_mask[n_cmd] <= int'(fix_mask);
            end
            n_cmd <= n_cmd + 1;
         end
         if (done) begin
            last_status <= int'(done_status);
            last_count  <= int'(done_count);
            n_done      <= n_done + 1;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic run(input logic [79:0] code, input bit dbl);
      int t;
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      stored_code = code;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (dbl) begin
         repeat (3) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      t = 0;
      while (n_done == 0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (n_done == 0) chk(1'b0, "R10", "watchdog done", 0, 1);
      repeat (4) @(negedge clk);
   endtask

   function automatic int st_of(int a);
      if (a < fake_len) return 3;
      if (a < fake_len + busy_len) return 12;
      return 0;
   endfunction

   int poll_at;
   function automatic int exp_delay();
      int k;
      int u;
      k = 1;
      while (!(st_of(k - 1) >= 4 || k == P)) k++;
      u = k + 1;
      while (st_of(u - 1) >= 4) u++;
      poll_at = u;
      return u + 1;
   endfunction

   int addr_tab [10] = '{7, 8, 519, 520, 0, 1023, 263, 512, 6, 300};

   initial begin
      logic [79:0] code;
      start = 1'b0; stored_code = '0; ready_mode = 1'b0; log_clr = 1'b1;
      fake_len = 0; busy_len = 0; final_st = 4'd0; final_cnt = 2'd0;
      for (int i = 0; i < 4; i++) syn_r[i] = '0;
      for (int i = 0; i < 2; i++) begin err_a[i] = '0; err_v[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!done && !fix_valid && !eng_load_en && !eng_rd_en && !eng_calc_start,
          "R10", "reset strobes low", {done, fix_valid, eng_load_en, eng_rd_en, eng_calc_start}, 0);
      rst_n = 1'b1;
      log_clr = 1'b0;
      @(negedge clk);

      // R1 erased sector
      run({80{1'b1}}, 1'b0);
      chk(last_status == 0, "R1", "erased status", last_status, 0);
      chk(last_count == 0, "R1", "erased count", last_count, 0);
      chk(n_load == 0 && n_rd == 0 && n_calc == 0, "R1", "erased engine accesses",
          n_load + n_rd + n_calc, 0);
      chk(n_done == 1, "R1", "erased done pulses", n_done, 1);

      // R1 negative: one byte not 0xFF
      code = {80{1'b1}};
      code[39:32] = 8'hFE;
      run(code, 1'b0);
      chk(n_load == 8, "R1", "near-erased takes full path", n_load, 8);
      chk(last_status == 1, "R1", "near-erased clean", last_status, 1);

      // R2 R3 clean sweep
      for (int t = 0; t < 6; t++) begin
         for (int b = 0; b < 10; b++) code[8*b +: 8] = 8'((t * 53 + b * 29 + 7) & 255);
         run(code, t == 2);
         chk(n_load == 8, "R2", "load count", n_load, 8);
         for (int j = 0; j < 8; j++)
            chk(load_log[j] == int'(code[(7 - j) * 10 +: 10]), "R2", "load value order",
                load_log[j], code[(7 - j) * 10 +: 10]);
         chk(n_rd == 4, "R3", "syndrome read count", n_rd, 4);
         for (int j = 0; j < 4; j++)
            chk(rd_sel_log[j] == j, "R3", "syndrome selector", rd_sel_log[j], j);
         chk(n_calc == 0, "R3", "no calc on zero syndrome", n_calc, 0);
         chk(last_status == 1 && last_count == 0, "R3", "clean result",
             last_status * 10 + last_count, 10);
         chk(n_done == 1, "R10", "single done despite extra start", n_done, 1);
      end

      // R4..R9 error sweep
      ready_mode = 1'b1;
      begin
         int r;
         r = 0;
         for (int fs = 0; fs < 4; fs++)
            for (int fc = 0; fc < 4; fc++)
               for (int fk = 0; fk < 3; fk++)
                  for (int bz = 0; bz < 2; bz++) begin
                     int a [4];
                     int v [4];
                     int ed, obs, n, ec;
                     int e_off [4];
                     int e_msk [4];
                     fake_len = (fk == 0) ? 0 : (fk == 1) ? 3 : P + 4;
                     busy_len = bz * 5;
                     final_st = 4'(fs);
                     final_cnt = 2'(fc);
                     for (int i = 0; i < 4; i++) syn_r[i] = '0;
                     syn_r[r % 4] = 32'h1 << (r % 29);
                     for (int i = 0; i < 4; i++) begin
                        a[i] = addr_tab[(r * 3 + i) % 10];
                        v[i] = (r * 37 + i * 11 + 1) % 256;
                     end
                     err_a[0] = {6'h2A, 10'(a[1]), 6'h15, 10'(a[0])};
                     err_a[1] = {6'h2A, 10'(a[3]), 6'h15, 10'(a[2])};
                     err_v[0] = {8'hA5, 8'(v[1]), 8'h5A, 8'(v[0])};
                     err_v[1] = {8'hA5, 8'(v[3]), 8'h5A, 8'(v[2])};
                     run(80'h0123_4567_89AB_CDEF_0011, 1'b0);
                     ed  = exp_delay();
                     obs = (poll_at - 1 < fake_len) ? 3 : fs;
                     chk(n_calc == 1, "R4", "single calc start", n_calc, 1);
                     chk(rd_sel_log[4] == 4, "R4", "flush selector", rd_sel_log[4], 4);
                     chk(rd_cyc_log[4] == calc_cyc - 1, "R4", "flush cycle",
                         rd_cyc_log[4], calc_cyc - 1);
                     chk(n_rd > 5 && rd_cyc_log[5] - calc_cyc == ed, "R5", "first poll-result read delay",
                         rd_cyc_log[5] - calc_cyc, ed);
                     if (obs < 2) begin
                        chk(n_rd == 6 && rd_sel_log[5] == 6, "R6", "tail read", rd_sel_log[5], 6);
                        chk(last_status == (obs == 0 ? 1 : 3), "R6", "end status",
                            last_status, obs == 0 ? 1 : 3);
                        chk(last_count == 0 && n_cmd == 0, "R6", "no commands", n_cmd, 0);
                     end else begin
                        n = fc + 1;
                        chk(n_rd == 5 + 2 * n, "R7", "result reads", n_rd, 5 + 2 * n);
                        for (int i = 0; i < n; i++) begin
                           chk(rd_sel_log[5 + 2 * i] == (i < 2 ? 4 : 5), "R7", "address selector",
                               rd_sel_log[5 + 2 * i], i < 2 ? 4 : 5);
                           chk(rd_sel_log[6 + 2 * i] == (i < 2 ? 6 : 7), "R7", "value selector",
                               rd_sel_log[6 + 2 * i], i < 2 ? 6 : 7);
                        end
                        ec = 0;
                        for (int i = 0; i < n; i++) begin
                           int off;
                           off = 519 - a[i];
                           if (off >= 0 && off < SB) begin
                              e_off[ec] = off;
                              e_msk[ec] = v[i];
                              ec++;
                           end
                        end
                        chk(n_cmd == ec, "R8", "command count", n_cmd, ec);
                        chk(last_count == ec, "R8", "done count", last_count, ec);
                        chk(last_status == 2, "R8", "corrected status", last_status, 2);
                        for (int i = 0; i < ec && i < n_cmd; i++) begin
                           chk(cmd_off[i] == e_off[i], "R9", "command offset in order",
                               cmd_off[i], e_off[i]);
                           chk(cmd_mask[i] == e_msk[i], "R7", "command mask half",
                               cmd_mask[i], e_msk[i]);
                        end
                     end
                     chk(n_done == 1, "R10", "one done per sector", n_done, 1);
                     r++;
                  end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule